// File: doc/BRIEF.md
# Prioritized Flash Read Scheduler

This block decides which bus master's read is being fetched from a serial flash at any moment. Each master posts a read as a single-cycle strobe carrying its ID, a byte address and a length counted in 64-bit beats. The scheduler keeps three slots: the transfer that is running, one transfer that a more important master has pushed aside, and one pending pre-emption waiting for the current beat to finish. It drives a flash engine one beat at a time over a request/ready handshake, and it forwards each returned beat to the owning master as a one-cycle pulse tagged with the master ID.

Every master's priority comes from its own field of a configuration vector. A strictly more important master interrupts a running read, but only between beats. The interrupted read keeps its next address and its remaining beat count, and it continues once the interrupting read has returned all of its data. A master that asks for a different location throws away its own running, pending or parked read. If it asks again for the location it is already reading, that is taken as a continuation and the read carries on.

Top module: `fsched_top`

## Requirements
- R1: While rst_n is low and in the cycle after it is released, fl_req and rd_beat are 0.
- R2: The running transfer issues exactly one beat at a time. A beat is issued when fl_req and fl_ready are both 1 at a clock edge, and the next beat is not requested until fl_dvalid has returned the previous one. Beat k of a request goes to the aligned start address plus 8*k, and the transfer stops after req_len beats. Each beat that is kept produces a one-cycle rd_beat, with rd_mid naming the owner, one cycle after its fl_dvalid.
- R3: While fl_req is high and fl_ready is low, and no request strobe arrives, fl_req stays high and fl_addr does not change.
- R4: A request from a master whose priority is strictly higher than that of the running transfer pre-empts it only between beats. The beat already in flight is delivered to its own master before the new master's first beat is issued.
- R5: A pre-empted transfer resumes only after every beat of the pre-empting transfer has been delivered. It continues from its next undelivered address and with its remaining count, not from its start.
- R6: A request from a different master whose priority is equal to or lower than that of the running transfer is dropped and never produces a beat.
- R7: At most one transfer is parked. While a transfer is parked, a request from any other master that would otherwise pre-empt is dropped.
- R8: A request from the master of the running transfer to a different address aborts that transfer in the same cycle. Its remaining beats are never issued, a beat of it still in flight is swallowed (it produces no rd_beat), and the new request starts once that beat has returned.
- R9: A request from the master of the running or parked transfer whose address equals the address of that transfer's next undelivered beat changes nothing.
- R10: A request from the master of the parked transfer to a different address discards the parked transfer. The request is then treated as a fresh one against the running transfer.
- R11: The priority of master m is cfg_prio[m*PRIO_W +: PRIO_W]. A larger value means more important, and the value is captured when the request is accepted.
- R12: A request with req_len equal to 0 is ignored entirely, including for aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prio | input | N_MST*PRIO_W | Per-master priority fields |
| req_valid | input | 1 | Request strobe, one cycle |
| req_mid | input | MID_W | Requesting master |
| req_addr | input | ADDR_W | Byte start address (low bits cleared) |
| req_len | input | LEN_W | Length in 64-bit beats |
| fl_req | output | 1 | Beat request to the flash engine |
| fl_addr | output | ADDR_W | Address of the requested beat |
| fl_ready | input | 1 | Engine accepts the beat request |
| fl_dvalid | input | 1 | Engine returns the outstanding beat |
| rd_beat | output | 1 | A kept beat is delivered |
| rd_mid | output | MID_W | Owner of the delivered beat |

## Verification
A slot holding a wrong address or count shows up at fl_addr on the very next beat request, and as a surplus or missing rd_beat once that transfer drains. A lost parked slot means the interrupted master never gets its tail beats. Bad handling of the in-flight beat puts an extra or missing rd_beat within a few cycles of an abort or pre-emption. For this reason the checks compare the complete ordered list of issued addresses and delivered owners for each scenario, and do not only sample single cycles.

// File: rtl/fsched_pkg.sv
package fsched_pkg;

   // Outcome of looking at one incoming request against the held slots
   typedef enum logic [2:0] {
      REQ_NONE,
      REQ_TAKE_IDLE,
      REQ_PREEMPT,
      REQ_RESTART_ACT,
      REQ_RESTART_PEND,
      REQ_KEEP,
      REQ_DROP
   } req_kind_e;

endpackage

// File: rtl/fsched_prio_lut.sv
module fsched_prio_lut #(
   parameter int N_MST  = 4,
   parameter int PRIO_W = 3,
   parameter int MID_W  = 2
) (
   input  logic [N_MST*PRIO_W-1:0] cfg_i,
   input  logic [MID_W-1:0]        mid_i,
   output logic [PRIO_W-1:0]       prio_o
);

   logic [PRIO_W-1:0] tbl [N_MST];

   for (genvar i = 0; i < N_MST; i++) begin : g_field
      assign tbl[i] = cfg_i[i*PRIO_W +: PRIO_W];
   end

   assign prio_o = (int'(mid_i) < N_MST) ? tbl[mid_i] : '0;

endmodule

// File: rtl/fsched_req_classify.sv
module fsched_req_classify
   import fsched_pkg::*;
#(
   parameter int MID_W  = 2,
   parameter int ADDR_W = 24,
   parameter int PRIO_W = 3
) (
   input  logic              valid_i,
   input  logic              len_nz_i,
   input  logic [MID_W-1:0]  mid_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PRIO_W-1:0] prio_i,
   input  logic              act_v_i,
   input  logic [MID_W-1:0]  act_mid_i,
   input  logic [ADDR_W-1:0] act_addr_i,
   input  logic [PRIO_W-1:0] act_prio_i,
   input  logic              pend_v_i,
   input  logic [MID_W-1:0]  pend_mid_i,
   input  logic [ADDR_W-1:0] pend_addr_i,
   input  logic              susp_v_i,
   input  logic [MID_W-1:0]  susp_mid_i,
   input  logic [ADDR_W-1:0] susp_addr_i,
   output req_kind_e         kind_o,
   output logic              kill_susp_o
);

   logic own_act, own_pend, own_susp, susp_free;

   assign own_act  = act_v_i  && (act_mid_i  == mid_i);
   assign own_pend = pend_v_i && (pend_mid_i == mid_i);
   assign own_susp = susp_v_i && (susp_mid_i == mid_i);

   always_comb begin
      kind_o      = REQ_NONE;
      kill_susp_o = 1'b0;
      susp_free   = !susp_v_i;
      if (valid_i && len_nz_i) begin
         if (own_act) begin
            kind_o = (addr_i == act_addr_i) ? REQ_KEEP : REQ_RESTART_ACT;
         end else if (own_pend) begin
            kind_o = (addr_i == pend_addr_i) ? REQ_KEEP : REQ_RESTART_PEND;
         end else if (own_susp && (addr_i == susp_addr_i)) begin
            kind_o = REQ_KEEP;
         end else begin
            kill_susp_o = own_susp;
            susp_free   = !susp_v_i || own_susp;
            if (!act_v_i)
               kind_o = REQ_TAKE_IDLE;
            else if (susp_free && !pend_v_i && (prio_i > act_prio_i))
               kind_o = REQ_PREEMPT;
            else
               kind_o = REQ_DROP;
         end
      end
   end

endmodule

// File: rtl/fsched_beat_track.sv
module fsched_beat_track (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   input  logic dvalid_i,
   input  logic kill_i,
   output logic outst_o,
   output logic outst_next_o,
   output logic deliver_o
);

   logic outst_q, discard_q, discard_d, ret;

   assign ret          = dvalid_i && outst_q;
   assign outst_next_o = issue_i ? 1'b1 : (ret ? 1'b0 : outst_q);
   assign deliver_o    = ret && !discard_q;
   assign outst_o      = outst_q;

   always_comb begin
      discard_d = ret ? 1'b0 : discard_q;
      if (kill_i && outst_next_o) discard_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst_q   <= 1'b0;
         discard_q <= 1'b0;
      end else begin
         outst_q   <= outst_next_o;
         discard_q <= discard_d;
      end
   end

   // Data may only come back for a beat that was actually issued
   assert_no_orphan_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid_i |-> outst_q);

endmodule

// File: rtl/fsched_top.sv
module fsched_top
   import fsched_pkg::*;
#(
   parameter int N_MST      = 4,
   parameter int ADDR_W     = 24,
   parameter int LEN_W      = 8,
   parameter int PRIO_W     = 3,
   parameter int BEAT_BYTES = 8,
   parameter bit ALIGN_REQ  = 1'b1,
   localparam int MID_W     = $clog2(N_MST),
   localparam int OFS_W     = $clog2(BEAT_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_MST*PRIO_W-1:0] cfg_prio,
   input  logic                    req_valid,
   input  logic [MID_W-1:0]        req_mid,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LEN_W-1:0]        req_len,
   output logic                    fl_req,
   output logic [ADDR_W-1:0]       fl_addr,
   input  logic                    fl_ready,
   input  logic                    fl_dvalid,
   output logic                    rd_beat,
   output logic [MID_W-1:0]        rd_mid
);

   // Elaboration-time parameter checks
   if (N_MST < 2) begin : g_bad_mst
      $error("fsched_top: N_MST must be at least 2");
   end
   if ((BEAT_BYTES < 1) || ((BEAT_BYTES & (BEAT_BYTES - 1)) != 0)) begin : g_bad_beat
      $error("fsched_top: BEAT_BYTES must be a power of two");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("fsched_top: ADDR_W too small for the beat size");
   end
   if ((PRIO_W < 1) || (LEN_W < 1)) begin : g_bad_w
      $error("fsched_top: PRIO_W and LEN_W must be positive");
   end

   typedef struct packed {
      logic              v;
      logic [MID_W-1:0]  mid;
      logic [ADDR_W-1:0] addr;
      logic [LEN_W-1:0]  rem;
      logic [PRIO_W-1:0] prio;
   } slot_t;

   slot_t act_q, susp_q, pend_q;
   slot_t a1, s1, p1;
   slot_t a2, s2, p2, nw;

   logic [ADDR_W-1:0] req_addr_al;
   logic [PRIO_W-1:0] req_prio;
   logic              issue, outst, outst_next, deliver, kill_susp, kill_act;
   req_kind_e         kind;

   // Request address: beat-aligned or passed through
   if (ALIGN_REQ) begin : g_align
      assign req_addr_al = req_addr & ~ADDR_W'(BEAT_BYTES - 1);
   end else begin : g_raw
      assign req_addr_al = req_addr;
   end

   fsched_prio_lut #(
      .N_MST (N_MST),
      .PRIO_W(PRIO_W),
      .MID_W (MID_W)
   ) u_prio (
      .cfg_i (cfg_prio),
      .mid_i (req_mid),
      .prio_o(req_prio)
   );

   assign fl_req  = act_q.v && !outst;
   assign fl_addr = act_q.addr;
   assign issue   = fl_req && fl_ready;

   fsched_beat_track u_beat (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_i     (issue),
      .dvalid_i    (fl_dvalid),
      .kill_i      (kill_act),
      .outst_o     (outst),
      .outst_next_o(outst_next),
      .deliver_o   (deliver)
   );

   // Stage 1: retire the returned beat, then resume a parked transfer
   always_comb begin
      a1 = act_q;
      s1 = susp_q;
      p1 = pend_q;
      if (deliver) begin
         a1.addr = a1.addr + ADDR_W'(BEAT_BYTES);
         a1.rem  = a1.rem - LEN_W'(1);
         if (a1.rem == '0) a1.v = 1'b0;
      end
      if (!a1.v && !p1.v && s1.v) begin
         a1   = s1;
         s1.v = 1'b0;
      end
   end

   fsched_req_classify #(
      .MID_W (MID_W),
      .ADDR_W(ADDR_W),
      .PRIO_W(PRIO_W)
   ) u_cls (
      .valid_i    (req_valid),
      .len_nz_i   (req_len != '0),
      .mid_i      (req_mid),
      .addr_i     (req_addr_al),
      .prio_i     (req_prio),
      .act_v_i    (a1.v),
      .act_mid_i  (a1.mid),
      .act_addr_i (a1.addr),
      .act_prio_i (a1.prio),
      .pend_v_i   (p1.v),
      .pend_mid_i (p1.mid),
      .pend_addr_i(p1.addr),
      .susp_v_i   (s1.v),
      .susp_mid_i (s1.mid),
      .susp_addr_i(s1.addr),
      .kind_o     (kind),
      .kill_susp_o(kill_susp)
   );

   assign kill_act = (kind == REQ_RESTART_ACT);

   // Stage 2: apply the request; stage 3: pre-empt at a beat boundary
   always_comb begin
      nw.v    = 1'b1;
      nw.mid  = req_mid;
      nw.addr = req_addr_al;
      nw.rem  = req_len;
      nw.prio = req_prio;
      a2 = a1;
      s2 = s1;
      p2 = p1;
      case (kind)
         REQ_TAKE_IDLE, REQ_RESTART_ACT: a2 = nw;
         REQ_PREEMPT, REQ_RESTART_PEND:  p2 = nw;
         default: ;
      endcase
      if (kill_susp) s2.v = 1'b0;
      if (p2.v && !outst_next) begin
         if (a2.v) s2 = a2;
         a2   = p2;
         p2.v = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= '0;
         susp_q  <= '0;
         pend_q  <= '0;
         rd_beat <= 1'b0;
         rd_mid  <= '0;
      end else begin
         act_q   <= a2;
         susp_q  <= s2;
         pend_q  <= p2;
         rd_beat <= deliver;
         rd_mid  <= act_q.mid;
      end
   end

   // An accepted beat request blocks the next one for at least a cycle
   assert_single_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && fl_ready) |=> !fl_req);

   // A waiting beat request is held steady
   assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && !fl_ready && !req_valid) |=> (fl_req && $stable(fl_addr)));

   // A pending pre-emption only exists while a beat is in flight
   assert_preempt_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q.v |-> (act_q.v && outst));

   // Never a parked transfer and a further pre-emption at the same time
   assert_one_susp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(susp_q.v && pend_q.v));

endmodule

// File: tb/tb_fsched_top.sv
`timescale 1ns/1ps
module tb_fsched_top;

   localparam int N_MST  = 4;
   localparam int ADDR_W = 24;
   localparam int LEN_W  = 8;
   localparam int PRIO_W = 3;
   localparam int MID_W  = 2;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [N_MST*PRIO_W-1:0] cfg_prio = '0;
   logic                    req_valid = 1'b0;
   logic [MID_W-1:0]        req_mid = '0;
   logic [ADDR_W-1:0]       req_addr = '0;
   logic [LEN_W-1:0]        req_len = '0;
   logic                    fl_req;
   logic [ADDR_W-1:0]       fl_addr;
   logic                    fl_ready = 1'b0;
   logic                    fl_dvalid = 1'b0;
   logic                    rd_beat;
   logic [MID_W-1:0]        rd_mid;

   fsched_top dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_prio (cfg_prio),
      .req_valid(req_valid),
      .req_mid  (req_mid),
      .req_addr (req_addr),
      .req_len  (req_len),
      .fl_req   (fl_req),
      .fl_addr  (fl_addr),
      .fl_ready (fl_ready),
      .fl_dvalid(fl_dvalid),
      .rd_beat  (rd_beat),
      .rd_mid   (rd_mid)
   );

   always #4 clk = ~clk;   // 125 MHz

   int n_total = 0;
   int n_pass  = 0;
   bit finished = 1'b0;

   logic [ADDR_W-1:0] iss_addr [256];
   int                dlv_mid  [256];
   logic [ADDR_W-1:0] exp_addr [256];
   int                exp_mid  [256];
   int iss_n = 0, dlv_n = 0, exp_an = 0, exp_mn = 0;

   bit hold_ready = 1'b0;
   bit busy = 1'b0;
   int lat = 0;

   // Flash engine model and logging, all at the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         busy = 1'b0; fl_dvalid = 1'b0; fl_ready = 1'b0;
      end else begin
         fl_dvalid = 1'b0;
         if (busy) begin
            lat = lat - 1;
            if (lat == 0) begin fl_dvalid = 1'b1; busy = 1'b0; end
         end
         fl_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
         if (fl_req && fl_ready) begin
            if (iss_n < 256) iss_addr[iss_n] = fl_addr;
            iss_n = iss_n + 1;
            busy = 1'b1;
            lat = 3 + ($urandom % 3);
         end
         if (rd_beat) begin
            if (dlv_n < 256) dlv_mid[dlv_n] = int'(rd_mid);
            dlv_n = dlv_n + 1;
         end
      end
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      n_total++;
      if (ok) n_pass++;
      else $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
   endtask

   function automatic logic [ADDR_W-1:0] align8(input logic [ADDR_W-1:0] a);
      return a & ~ADDR_W'(7);
   endfunction

   task automatic clear_logs();
      iss_n = 0; dlv_n = 0; exp_an = 0; exp_mn = 0;
   endtask

   // Expected beats first..first+cnt-1 of a transfer, issued and delivered
   task automatic exp_run(input int m, input logic [ADDR_W-1:0] a, input int first, input int cnt);
      for (int i = first; i < first + cnt; i++) begin
         exp_addr[exp_an] = align8(a) + ADDR_W'(8 * i);
         exp_an++;
         exp_mid[exp_mn] = m;
         exp_mn++;
      end
   endtask

   task automatic exp_issue_only(input logic [ADDR_W-1:0] a);
      exp_addr[exp_an] = a;
      exp_an++;
   endtask

   task automatic setp(input int m, input int p);
      cfg_prio[m*PRIO_W +: PRIO_W] = PRIO_W'(p);
   endtask

   task automatic send(input int m, input logic [ADDR_W-1:0] a, input int l);
      @(negedge clk);
      req_valid = 1'b1; req_mid = MID_W'(m); req_addr = a; req_len = LEN_W'(l);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_iss(input int k);
      while (iss_n < k) @(negedge clk);
   endtask

   task automatic wait_idle();
      int q = 0;
      while (q < 8) begin
         @(negedge clk);
         if (!fl_req && !busy && !req_valid && !rd_beat) q++;
         else q = 0;
      end
   endtask

   task automatic compare(input string rq);
      int mis;
      check(iss_n == exp_an, rq, "issued beat count", iss_n, exp_an);
      mis = -1;
      for (int i = 0; i < iss_n && i < exp_an; i++)
         if (mis < 0 && iss_addr[i] != exp_addr[i]) mis = i;
      check(mis < 0, rq, "issued address",
            (mis < 0) ? 0 : int'(iss_addr[mis]), (mis < 0) ? 0 : int'(exp_addr[mis]));
      check(dlv_n == exp_mn, rq, "delivered beat count", dlv_n, exp_mn);
      mis = -1;
      for (int i = 0; i < dlv_n && i < exp_mn; i++)
         if (mis < 0 && dlv_mid[i] != exp_mid[i]) mis = i;
      check(mis < 0, rq, "delivered owner",
            (mis < 0) ? 0 : dlv_mid[mis], (mis < 0) ? 0 : exp_mid[mis]);
   endtask

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_total++;
         $display("FAIL watchdog run did not complete actual=%0d expected=%0d", iss_n, exp_an);
         $display("%0d/%0d checks passed", n_pass, n_total);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] aa, ab;
      void'($urandom(32'h00c0ffee));

      // R1: reset state
      repeat (3) @(negedge clk);
      check(fl_req == 1'b0, "R1", "fl_req in reset", int'(fl_req), 0);
      check(rd_beat == 1'b0, "R1", "rd_beat in reset", int'(rd_beat), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(fl_req == 1'b0 && rd_beat == 1'b0, "R1", "outputs after release",
            int'({fl_req, rd_beat}), 0);

      // R2: single transfers, random master, address and length
      for (int i = 0; i < 6; i++) begin
         int m, l;
         m = $urandom % N_MST;
         l = 1 + ($urandom % 6);
         aa = ADDR_W'($urandom) & 24'h7FFFFF;
         clear_logs();
         send(m, aa, l);
         wait_idle();
         exp_run(m, aa, 0, l);
         compare("R2");
      end

      // R4 R5 R11: random pre-emptions at random beat positions
      for (int i = 0; i < 6; i++) begin
         int ma, mb, pa, la, lb, k;
         ma = $urandom % N_MST;
         mb = (ma + 1 + ($urandom % 3)) % N_MST;
         pa = $urandom % 4;
         setp(ma, pa);
         setp(mb, pa + 1 + ($urandom % 3));
         la = 2 + ($urandom % 5);
         k  = 1 + ($urandom % la);
         lb = 1 + ($urandom % 4);
         aa = ADDR_W'($urandom) & 24'h3FFFF8;
         ab = (ADDR_W'($urandom) & 24'h3FFFF8) | 24'h400000;
         clear_logs();
         send(ma, aa, la);
         wait_iss(k);
         send(mb, ab, lb);
         wait_idle();
         exp_run(ma, aa, 0, k);
         exp_run(mb, ab, 0, lb);
         exp_run(ma, aa, k, la - k);
         compare("R4 R5 R11");
      end

      // R3: request held while the engine is not ready
      clear_logs();
      hold_ready = 1'b1;
      send(1, 24'h000100, 2);
      repeat (5) @(negedge clk);
      check(fl_req == 1'b1 && fl_addr == 24'h000100, "R3", "held beat request",
            int'(fl_addr), 'h100);
      hold_ready = 1'b0;
      wait_idle();

      // R6: equal and lower priority requests are dropped
      setp(0, 3); setp(1, 3); setp(2, 1);
      clear_logs();
      send(0, 24'h001000, 4);
      wait_iss(1);
      send(1, 24'h002000, 3);
      send(2, 24'h003000, 3);
      wait_idle();
      exp_run(0, 24'h001000, 0, 4);
      compare("R6");

      // R7: only one transfer parked
      setp(0, 1); setp(1, 4); setp(2, 6);
      clear_logs();
      send(0, 24'h010000, 5);
      wait_iss(2);
      send(1, 24'h020000, 4);
      wait_iss(3);
      send(2, 24'h030000, 3);
      wait_idle();
      exp_run(0, 24'h010000, 0, 2);
      exp_run(1, 24'h020000, 0, 4);
      exp_run(0, 24'h010000, 2, 3);
      compare("R7");

      // R8: own master to a new location aborts at once
      setp(0, 2);
      clear_logs();
      send(0, 24'h040000, 6);
      wait_iss(3);
      send(0, 24'h041000, 3);
      wait_idle();
      exp_run(0, 24'h040000, 0, 2);
      exp_issue_only(24'h040010);
      exp_run(0, 24'h041000, 0, 3);
      compare("R8");

      // R9: same master, same next location, is a continuation
      clear_logs();
      send(0, 24'h050000, 4);
      wait_iss(2);
      send(0, 24'h050008, 9);
      wait_idle();
      exp_run(0, 24'h050000, 0, 4);
      compare("R9");

      // R10: parked master moves elsewhere; parked transfer discarded
      setp(0, 1); setp(1, 5);
      clear_logs();
      send(0, 24'h060000, 5);
      wait_iss(2);
      send(1, 24'h070000, 4);
      wait_iss(3);
      send(0, 24'h062000, 3);
      wait_idle();
      exp_run(0, 24'h060000, 0, 2);
      exp_run(1, 24'h070000, 0, 4);
      compare("R10");

      // R12: zero-length requests ignored, also as an abort
      clear_logs();
      send(3, 24'h080000, 0);
      wait_idle();
      compare("R12");
      clear_logs();
      send(0, 24'h090000, 3);
      wait_iss(1);
      send(0, 24'h095000, 0);
      wait_idle();
      exp_run(0, 24'h090000, 0, 3);
      compare("R12");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
   end

endmodule